// File: doc/BRIEF.md
# Multicore Reset Controller Register Block

This block is the register front end of a reset controller for a cluster of four processor cores. A simple 32-bit register bus with a 4 KB byte window reaches sixteen 32-bit registers: a control register, two boot-mode words, a reset-status word, an interrupt-status word, an interrupt-mask word and ten general-purpose words. Every register except the control register simply stores what is written.

A write to the control register is compared with the value it replaces, and only the bits that differ cause actions. A changed per-core reset bit produces a one-cycle reset pulse to that core. A changed enable bit of a secondary core produces a power-on or power-off request. A power-on request carries an entry address and an argument taken from that core's own pair of general-purpose registers. Reset bits, and the two display-unit software reset bits, never read back as 1: they clear themselves. Power requests leave the block as single-cycle strobes, one per cycle, with the highest-numbered core first.

Top module: `core_reset_ctrl`

## Requirements
- R1: After reset every register reads zero except index 0 (control) = 0x00000521, index 2 (reset status) = 0x00000001 and index 4 (interrupt mask) = 0x0000001F.
- R2: The register index is addr_i[11:2]. An access with addr_i[1:0] not zero is ignored: a read returns zero and a write changes no register.
- R3: An access whose index is 16 or more reads zero, and a write to it changes no register.
- R4: A write to any index from 1 to 15 stores wdata_i unchanged, readable at once.
- R5: Bits 13 to 16 of the control register are the reset bits of cores 0 to 3. When a write changes one of them (and R7 does not apply), core_rst_o[c] is 1 for exactly the one cycle after the write, and the bit is stored as 0.
- R6: Bits 22, 23 and 24 of the control register enable cores 1, 2 and 3. When a write changes one of them, a power request strobe (pwr_vld_o = 1) for that core is issued, with pwr_on_o = 1 when the new bit is 1 and 0 when it is 0; pwr_entry_o and pwr_arg_o carry the values held at the write in indices 8/9 for core 1, 10/11 for core 2 and 12/13 for core 3.
- R7: When a core's enable bit changes, its reset bit is stored as 0 and no reset pulse is issued to it by that write.
- R8: The power strobes of one write start in the cycle after the write and follow one per cycle in the order core 3, core 2, core 1, with no gaps; pwr_vld_o is 0 otherwise.
- R9: Bits 3 and 12 of the control register (display-unit software resets) are stored as 0 when a write changes them and drive no output.
- R10: Control bits that a write leaves unchanged cause no pulse and no power request; all other bits store the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i = 1 and we_i = 0 |
| core_rst_o | output | 4 | One-cycle reset pulse per core |
| pwr_vld_o | output | 1 | Power request strobe |
| pwr_on_o | output | 1 | 1 = power on, 0 = power off |
| pwr_core_o | output | 2 | Core the request targets |
| pwr_entry_o | output | 32 | Entry address of the request |
| pwr_arg_o | output | 32 | Argument of the request |

## Verification
A wrong next-value computation for the control register shows up on the very next read of index 0 as a reset or display bit reading 1, or as an enable bit that differs from the one written. A wrong change mask shows at the ports in the cycle after the write, as a missing or extra reset pulse or strobe. A pending power request that is lost, doubled or captured with the wrong register pair shows within three cycles of the write, as a gap, a repeated core, a wrong order or a wrong entry/argument on the strobe sequence.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;
  localparam int unsigned DW = 32;

  // control register bit map
  localparam int unsigned CORE_RST_LSB = 13;   // core c reset at 13+c
  localparam int unsigned CORE_EN_BASE = 21;   // core c enable at 21+c, c >= 1
  localparam int unsigned DISP_RST_A   = 3;
  localparam int unsigned DISP_RST_B   = 12;

  // register indices
  localparam int unsigned IDX_CTRL     = 0;
  localparam int unsigned IDX_RST_STAT = 2;
  localparam int unsigned IDX_IRQ_MASK = 4;
  localparam int unsigned IDX_GP_BASE  = 6;    // gp1 at 6 ... gp10 at 15

  localparam logic [DW-1:0] CTRL_INIT     = 32'h0000_0521;
  localparam logic [DW-1:0] RST_STAT_INIT = 32'h0000_0001;
  localparam logic [DW-1:0] IRQ_MASK_INIT = 32'h0000_001F;

  typedef struct packed {
    logic          on;
    logic [DW-1:0] entry;
    logic [DW-1:0] arg;
  } pwr_req_t;

  function automatic logic [DW-1:0] reg_init(input int unsigned idx);
    case (idx)
      IDX_CTRL:     return CTRL_INIT;
      IDX_RST_STAT: return RST_STAT_INIT;
      IDX_IRQ_MASK: return IRQ_MASK_INIT;
      default:      return '0;
    endcase
  endfunction

  // entry word of core c, argument word follows it
  function automatic int unsigned entry_idx(input int unsigned c);
    return IDX_GP_BASE + 2 * c;
  endfunction
endpackage

// File: rtl/core_rst_ctrl_decode.sv
module core_rst_ctrl_decode
  import core_rst_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [DW-1:0]        old_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        new_o,
  output logic [NUM_CORES-1:0] rst_pulse_o,
  output logic [NUM_CORES-1:0] en_chg_o,
  output logic [NUM_CORES-1:0] en_val_o
);
  logic [DW-1:0] chg;

  always_comb begin
    chg         = old_i ^ wdata_i;
    new_o       = wdata_i;
    rst_pulse_o = '0;
    en_chg_o    = '0;
    en_val_o    = '0;
    // enable changes swallow the core's own reset bit
    for (int c = NUM_CORES - 1; c >= 1; c--) begin
      if (chg[CORE_EN_BASE + c]) begin
        en_chg_o[c]              = 1'b1;
        en_val_o[c]              = wdata_i[CORE_EN_BASE + c];
        new_o[CORE_RST_LSB + c]  = 1'b0;
        chg[CORE_RST_LSB + c]    = 1'b0;
      end
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      if (chg[CORE_RST_LSB + c]) begin
        rst_pulse_o[c]          = 1'b1;
        new_o[CORE_RST_LSB + c] = 1'b0;
      end
    end
    if (chg[DISP_RST_A]) new_o[DISP_RST_A] = 1'b0;
    if (chg[DISP_RST_B]) new_o[DISP_RST_B] = 1'b0;
  end
endmodule

// File: rtl/core_rst_pwr_seq.sv
module core_rst_pwr_seq
  import core_rst_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CID_W    = $clog2(NUM_CORES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NUM_CORES-1:0]          chg_i,
  input  logic [NUM_CORES-1:0]          on_i,
  input  logic [NUM_CORES-1:0][DW-1:0]  entry_i,
  input  logic [NUM_CORES-1:0][DW-1:0]  arg_i,
  output logic                          vld_o,
  output logic                          on_o,
  output logic [CID_W-1:0]              core_o,
  output logic [DW-1:0]                 entry_o,
  output logic [DW-1:0]                 arg_o
);
  logic [NUM_CORES-1:0] pend_q;
  logic [NUM_CORES-1:0] grant;
  pwr_req_t             req_q [NUM_CORES];
  logic [CID_W-1:0]     sel;

  // highest pending core wins
  always_comb begin
    sel = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (pend_q[c]) sel = CID_W'(c);
  end

  assign vld_o   = |pend_q;
  assign core_o  = sel;
  assign on_o    = req_q[sel].on;
  assign entry_o = req_q[sel].entry;
  assign arg_o   = req_q[sel].arg;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    assign grant[c] = vld_o && (sel == CID_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[c] <= 1'b0;
        req_q[c]  <= '0;
      end else if (load_i && chg_i[c]) begin
        pend_q[c] <= 1'b1;
        req_q[c]  <= '{on: on_i[c], entry: entry_i[c], arg: arg_i[c]};
      end else if (grant[c]) begin
        pend_q[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/core_reset_ctrl.sv
module core_reset_ctrl
  import core_rst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned IDX_W    = ADDR_W - 2,
  localparam int unsigned CID_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_CORES-1:0] core_rst_o,
  output logic                 pwr_vld_o,
  output logic                 pwr_on_o,
  output logic [CID_W-1:0]     pwr_core_o,
  output logic [DW-1:0]        pwr_entry_o,
  output logic [DW-1:0]        pwr_arg_o
);
  logic [IDX_W-1:0]              idx;
  logic                          hit, wr_en, ctrl_wr;
  logic [DW-1:0]                 regs_q [NUM_REGS];
  logic [DW-1:0]                 ctrl_new;
  logic [NUM_CORES-1:0]          rst_pulse, en_chg, en_val;
  logic [NUM_CORES-1:0][DW-1:0]  entry_vec, arg_vec;
  logic [NUM_CORES-1:0]          core_rst_q;

  assign idx     = addr_i[ADDR_W-1:2];
  assign hit     = (addr_i[1:0] == 2'b00) && (32'(idx) < NUM_REGS);
  assign wr_en   = req_i && we_i && hit;
  assign ctrl_wr = wr_en && (32'(idx) == IDX_CTRL);

  core_rst_ctrl_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .old_i       (regs_q[IDX_CTRL]),
    .wdata_i     (wdata_i),
    .new_o       (ctrl_new),
    .rst_pulse_o (rst_pulse),
    .en_chg_o    (en_chg),
    .en_val_o    (en_val)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[i] <= reg_init(i);
      else if (wr_en && (32'(idx) == i))
        regs_q[i] <= (i == IDX_CTRL) ? ctrl_new : wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && hit)
      for (int i = 0; i < NUM_REGS; i++)
        if (32'(idx) == i) rdata_o = regs_q[i];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pair
    assign entry_vec[c] = regs_q[entry_idx(c)];
    assign arg_vec[c]   = regs_q[entry_idx(c) + 1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) core_rst_q <= '0;
    else         core_rst_q <= ctrl_wr ? rst_pulse : '0;
  end
  assign core_rst_o = core_rst_q;

  core_rst_pwr_seq #(.NUM_CORES(NUM_CORES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ctrl_wr),
    .chg_i   (en_chg),
    .on_i    (en_val),
    .entry_i (entry_vec),
    .arg_i   (arg_vec),
    .vld_o   (pwr_vld_o),
    .on_o    (pwr_on_o),
    .core_o  (pwr_core_o),
    .entry_o (pwr_entry_o),
    .arg_o   (pwr_arg_o)
  );
endmodule

// File: rtl/core_reset_ctrl_chk.sv
module core_reset_ctrl_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CID_W    = $clog2(NUM_CORES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          rdata_o,
  input logic [NUM_CORES-1:0] core_rst_o,
  input logic                 pwr_vld_o,
  input logic [CID_W-1:0]     pwr_core_o
);
  logic ctrl_wr, bad_rd, ctrl_rd;
  assign ctrl_wr = req_i && we_i && (addr_i == '0);
  assign ctrl_rd = req_i && !we_i && (addr_i == '0);
  assign bad_rd  = req_i && !we_i &&
                   ((addr_i[1:0] != 2'b00) || (32'(addr_i[ADDR_W-1:2]) >= NUM_REGS));

  AST_RST_AFTER_CTRL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|core_rst_o) |-> $past(ctrl_wr));                                   // R5
  AST_RST_BITS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |-> (rdata_o[16:13] == 4'b0));                               // R5
  AST_DISP_BITS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |-> (rdata_o[3] == 1'b0 && rdata_o[12] == 1'b0));            // R9
  AST_PWR_SECONDARY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_vld_o |-> (pwr_core_o != '0));                                   // R6
  AST_PWR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_vld_o && !$past(pwr_vld_o)) |-> $past(ctrl_wr));                // R8
  AST_PWR_DESCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_vld_o && $past(pwr_vld_o) && !$past(ctrl_wr))
      |-> (pwr_core_o < $past(pwr_core_o)));                             // R8
  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_rd |-> (rdata_o == '0));                                         // R3
endmodule

bind core_reset_ctrl core_reset_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_CORES(NUM_CORES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .core_rst_o(core_rst_o), .pwr_vld_o(pwr_vld_o),
  .pwr_core_o(pwr_core_o)
);

// File: tb/sim_core_reset_ctrl.sv
module sim_core_reset_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  core_rst;
  logic        pwr_vld, pwr_on;
  logic [1:0]  pwr_core;
  logic [31:0] pwr_entry, pwr_arg;

  int vectors = 0, fails = 0;
  logic [31:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  core_reset_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .core_rst_o(core_rst),
    .pwr_vld_o(pwr_vld), .pwr_on_o(pwr_on), .pwr_core_o(pwr_core),
    .pwr_entry_o(pwr_entry), .pwr_arg_o(pwr_arg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input int i);
    case (i)
      0: return 32'h521;
      2: return 32'h1;
      4: return 32'h1F;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // plain register write plus model update (R2, R3, R4)
  task automatic wr_plain(input logic [11:0] a, input logic [31:0] d);
    wr(a, d);
    if (a[1:0] == 2'b00 && a[11:2] < 16 && a[11:2] != 0) model[a[11:2]] = d;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(12'(i * 4), d);
      chk(tag, d, model[i]);
    end
  endtask

  // control write with expected pulse / strobe sequence
  task automatic ctrl_wr(input logic [31:0] w);
    logic [31:0] chg, nv, d;
    logic [3:0]  exp_pulse;
    int          n;
    int          e_core [3];
    logic        e_on [3];
    logic [31:0] e_ent [3], e_arg [3];
    chg = model[0] ^ w; nv = w; exp_pulse = '0; n = 0;
    for (int c = 3; c >= 1; c--) begin
      if (chg[21 + c]) begin
        e_core[n] = c; e_on[n] = w[21 + c];
        e_ent[n] = model[6 + 2*c]; e_arg[n] = model[7 + 2*c];
        n++;
        nv[13 + c] = 1'b0; chg[13 + c] = 1'b0;
      end
    end
    for (int c = 0; c < 4; c++)
      if (chg[13 + c]) begin exp_pulse[c] = 1'b1; nv[13 + c] = 1'b0; end
    if (chg[3])  nv[3] = 1'b0;
    if (chg[12]) nv[12] = 1'b0;
    model[0] = nv;
    wr(12'h000, w);
    chk("R5 R7 reset pulse", 32'(core_rst), 32'(exp_pulse));
    for (int k = 0; k < n; k++) begin
      chk("R8 strobe valid", 32'(pwr_vld), 32'd1);
      chk("R8 strobe core order", 32'(pwr_core), 32'(e_core[k]));
      chk("R6 on/off", 32'(pwr_on), 32'(e_on[k]));
      chk("R6 entry", pwr_entry, e_ent[k]);
      chk("R6 argument", pwr_arg, e_arg[k]);
      @(negedge clk);
      chk("R5 pulse one cycle", 32'(core_rst), 32'd0);
    end
    chk("R8 R10 no extra strobe", 32'(pwr_vld), 32'd0);
    if (n == 0) begin
      @(negedge clk);
      chk("R5 R10 pulse one cycle", 32'(core_rst), 32'd0);
    end
    rd(12'h000, d);
    chk("R5 R9 R10 control readback", d, nv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check_all("R1 reset value");
    chk("R5 no pulse after reset", 32'(core_rst), 32'd0);
    chk("R8 no strobe after reset", 32'(pwr_vld), 32'd0);

    // R3 out of range
    rd(12'h040, d); chk("R3 read beyond last", d, 32'd0);
    rd(12'hFFC, d); chk("R3 read top of window", d, 32'd0);
    wr_plain(12'h040, 32'hDEAD_BEEF);
    wr_plain(12'h800, 32'h1234_5678);
    check_all("R3 write beyond last");

    // R2 misaligned
    rd(12'h009, d); chk("R2 misaligned read", d, 32'd0);
    wr_plain(12'h022, 32'hCAFE_F00D);
    wr_plain(12'h003, 32'hFFFF_FFFF);
    check_all("R2 misaligned write");

    // R4 random plain writes
    for (int i = 0; i < 150; i++) begin
      int j = 1 + ($urandom % 15);
      wr_plain(12'(j * 4), $urandom);
      rd(12'(j * 4), d);
      chk("R4 store unchanged", d, model[j]);
    end

    // directed control cases
    ctrl_wr(32'h0001_E521);              // R5 all four resets
    ctrl_wr(32'h0001_E521);              // R5 again: stored 0, so changes again
    ctrl_wr(32'h01C1_E521);              // R6 R7 R8 enable 1..3 with resets
    ctrl_wr(model[0]);                   // R10 same value
    ctrl_wr(32'h0101_1529);              // R6 off 1,2 ; R9 display bits
    ctrl_wr(32'h0000_0521);              // R6 off 3
    ctrl_wr(32'h0040_0521);              // R6 single core 1

    // random control and register traffic
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 4;
      if (op == 0) wr_plain(12'((6 + ($urandom % 10)) * 4), $urandom);
      else if (op == 1) ctrl_wr(model[0]);
      else ctrl_wr($urandom);
    end
    check_all("R4 R10 final state");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule